// File: doc/BRIEF.md
# Multi-Context TDM Payload Assembler

This block sits behind a serial TDM front end. It collects 64 kb/s timeslot bytes into per-channel payloads. The front end delivers one sampled byte per timeslot, together with the timeslot index and a marker on the first byte of each frame. The timeslot space is 1024 slots wide, which covers either 32 streams at 2.048 Mb/s or 8 streams at 8.192 Mb/s.

Each channel, called a context, owns any set of timeslots, so its rate is N × 64 kb/s for N owned slots. Up to 128 contexts run side by side. A host write port maps timeslots to contexts, sets each context's payload length in frames, and clears overrun flags. Slot membership may change while traffic flows. A change is applied only at the next frame boundary and touches no other context.

Completed payloads leave on a byte stream with valid/ready handshake, a last marker and the context number as sideband. Payload storage is a small on-chip buffer per context.

Top module: `tsa_assembler`

## Requirements
- R1: After reset, `pl_valid` is low, every overrun flag is 0, every timeslot is unmapped and every context length is 1.
- R2: A host write with `cfg_sel`=0 programs timeslot `cfg_addr`. Bit 7 of `cfg_wdata` is the enable bit and bits 6:0 are the context number. A byte that arrives on a disabled timeslot is discarded and shows up in no payload.
- R3: A timeslot map write made in the middle of a frame takes effect from the next frame-start byte, and that frame-start byte already uses the new map. Bytes earlier in the current frame use the old map.
- R4: Accepted bytes appear in the payload in arrival order, both within a frame and across frames. The front end delivers a frame's slots in ascending index order.
- R5: A host write with `cfg_sel`=1 sets the length of context `cfg_addr` to `cfg_wdata[3:0]` frames; a value of 0 acts as 1. A context is counted as having received a frame only if at least one of its bytes was accepted in that frame. The context closes on the frame-start byte that ends its Nth such frame, and is then queued for output.
- R6: While `pl_valid` is high and `pl_ready` is low, `pl_data`, `pl_ctx` and `pl_last` hold steady.
- R7: A payload is sent as consecutive bytes. `pl_ctx` is constant across the whole payload, `pl_last` marks only the final byte, and the byte count equals the number of bytes that were accepted.
- R8: When several contexts are closed at once, they are sent lowest context number first, and each payload is finished before the next one starts.
- R9: A byte for a context that is closed, or whose 16-byte buffer is full, is dropped and sets that context's sticky bit in `ovr_flags`. A host write with `cfg_sel`=2 clears the bit of context `cfg_addr`.
- R10: An overrun, a map change or a payload in flight on one context leaves the payloads and flags of all other contexts unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ts_valid | input | 1 | A timeslot byte is present |
| ts_fs | input | 1 | This byte is the first of a frame |
| ts_slot | input | 10 | Timeslot index of the byte |
| ts_byte | input | 8 | Sampled timeslot byte |
| cfg_we | input | 1 | Host write strobe |
| cfg_sel | input | 2 | Write target: 0 map, 1 length, 2 overrun clear |
| cfg_addr | input | 10 | Timeslot index or context number |
| cfg_wdata | input | 8 | Write data |
| pl_valid | output | 1 | Payload byte valid |
| pl_ready | input | 1 | Sink accepts the byte |
| pl_data | output | 8 | Payload byte |
| pl_last | output | 1 | Final byte of the payload |
| pl_ctx | output | 7 | Context number of the payload |
| ovr_flags | output | 128 | Sticky per-context overrun flags |

## Verification
A wrong entry in the active map shows up as a missing or extra byte in a payload, and that is only visible once the affected context closes, up to its programmed number of frames later. A wrong frame counter or closed bit shows a payload that comes out too early, too late, or not at all. It can also set a spurious overrun flag, which appears one cycle after the offending byte. A wrong drain pointer or context register corrupts `pl_data`, `pl_last` or `pl_ctx` from the first cycle the payload is presented. For that reason the directed scenarios compare every byte, its sideband and the order in which contexts are sent.

// File: rtl/tsa_pkg.sv
package tsa_pkg;

    localparam int CTX_W = 7;

    typedef enum logic [1:0] {
        CFG_MAP = 2'd0,
        CFG_LEN = 2'd1,
        CFG_CLR = 2'd2,
        CFG_NOP = 2'd3
    } cfg_op_e;

    typedef struct packed {
        logic             en;
        logic [CTX_W-1:0] ctx;
    } map_ent_t;

    function automatic map_ent_t to_ent(input logic [CTX_W:0] raw);
        map_ent_t e;
        e.en  = raw[CTX_W];
        e.ctx = raw[CTX_W-1:0];
        return e;
    endfunction

endpackage

// File: rtl/tsa_slot_map.sv
module tsa_slot_map
    import tsa_pkg::*;
#(
    parameter int NUM_SLOTS = 1024,
    localparam int SW = $clog2(NUM_SLOTS)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          map_we,
    input  logic [SW-1:0] map_addr,
    input  map_ent_t      map_wdata,
    input  logic          fs_evt,
    input  logic [SW-1:0] lk_slot,
    output map_ent_t      lk_ent
);

    map_ent_t shadow [NUM_SLOTS];
    map_ent_t active [NUM_SLOTS];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < NUM_SLOTS; i++) begin
                shadow[i] <= '0;
                active[i] <= '0;
            end
        end else begin
            if (fs_evt) active <= shadow;
            if (map_we) shadow[map_addr] <= map_wdata;
        end
    end

    // the frame-start byte already sees the pending map
    assign lk_ent = fs_evt ? shadow[lk_slot] : active[lk_slot];

    assert_midframe_hold_R3: assert property (@(posedge clk) disable iff (rst)
        (map_we && !fs_evt) |=> active[$past(map_addr)] == $past(active[map_addr]));

    assert_commit_at_fs_R3: assert property (@(posedge clk) disable iff (rst)
        fs_evt |=> active[$past(lk_slot)] == $past(shadow[lk_slot]));

endmodule

// File: rtl/tsa_ctx_store.sv
module tsa_ctx_store
    import tsa_pkg::*;
#(
    parameter int NUM_CTX   = 128,
    parameter int BUF_BYTES = 16,
    parameter int LEN_W     = 4,
    localparam int IDX_W = $clog2(BUF_BYTES),
    localparam int PTR_W = $clog2(BUF_BYTES + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             fs_evt,
    input  logic             hit,
    input  logic [CTX_W-1:0] hit_ctx,
    input  logic [7:0]       hit_byte,
    input  logic             len_we,
    input  logic             clr_we,
    input  logic [CTX_W-1:0] cfg_ctx,
    input  logic [LEN_W-1:0] len_wdata,
    input  logic             rel,
    input  logic [CTX_W-1:0] rel_ctx,
    input  logic [CTX_W-1:0] rd_ctx,
    input  logic [IDX_W-1:0] rd_idx,
    output logic [7:0]       rd_byte,
    output logic [PTR_W-1:0] rd_len,
    output logic [NUM_CTX-1:0] closed_v,
    output logic [NUM_CTX-1:0] ovr_v
);

    localparam logic [PTR_W-1:0] CAP = PTR_W'(BUF_BYTES);
    localparam logic [LEN_W:0]   ONE = (LEN_W+1)'(1);

    logic [7:0]       mem   [NUM_CTX][BUF_BYTES];
    logic [PTR_W-1:0] ptr   [NUM_CTX];
    logic [LEN_W-1:0] frm   [NUM_CTX];
    logic [LEN_W-1:0] len_r [NUM_CTX];
    logic [NUM_CTX-1:0] seen, closed, ovr, closing;
    logic acc;

    always_comb begin
        for (int c = 0; c < NUM_CTX; c++) begin
            closing[c] = fs_evt && !closed[c] && seen[c] &&
                (({1'b0, frm[c]} + ONE) >=
                 ((len_r[c] == '0) ? ONE : {1'b0, len_r[c]}));
        end
    end

    assign acc = hit && !closed[hit_ctx] && !closing[hit_ctx] && (ptr[hit_ctx] < CAP);

    always_ff @(posedge clk) begin
        if (rst) begin
            seen   <= '0;
            closed <= '0;
            ovr    <= '0;
            for (int c = 0; c < NUM_CTX; c++) begin
                ptr[c]   <= '0;
                frm[c]   <= '0;
                len_r[c] <= LEN_W'(1);
            end
        end else begin
            if (fs_evt) begin
                for (int c = 0; c < NUM_CTX; c++) begin
                    seen[c] <= 1'b0;
                    if (closing[c])   closed[c] <= 1'b1;
                    else if (seen[c]) frm[c]    <= frm[c] + 1'b1;
                end
            end
            if (rel) begin
                closed[rel_ctx] <= 1'b0;
                ptr[rel_ctx]    <= '0;
                frm[rel_ctx]    <= '0;
                seen[rel_ctx]   <= 1'b0;
            end
            if (len_we) len_r[cfg_ctx] <= len_wdata;
            if (clr_we) ovr[cfg_ctx]   <= 1'b0;
            if (acc) begin
                ptr[hit_ctx]  <= ptr[hit_ctx] + 1'b1;
                seen[hit_ctx] <= 1'b1;
            end else if (hit) begin
                ovr[hit_ctx] <= 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (acc) mem[hit_ctx][ptr[hit_ctx][IDX_W-1:0]] <= hit_byte;
    end

    assign rd_byte  = mem[rd_ctx][rd_idx];
    assign rd_len   = ptr[rd_ctx];
    assign closed_v = closed;
    assign ovr_v    = ovr;

    assert_drop_flags_R9: assert property (@(posedge clk) disable iff (rst)
        (hit && !acc) |=> ovr_v[$past(hit_ctx)]);

    assert_sticky_ovr_R9: assert property (@(posedge clk) disable iff (rst)
        !clr_we |=> ((ovr_v & $past(ovr_v)) == $past(ovr_v)));

    assert_closed_frozen_R10: assert property (@(posedge clk) disable iff (rst)
        (closed_v[rd_ctx] && !rel) |=> $stable(rd_len));

endmodule

// File: rtl/tsa_drain.sv
module tsa_drain
    import tsa_pkg::*;
#(
    parameter int NUM_CTX   = 128,
    parameter int BUF_BYTES = 16,
    localparam int IDX_W = $clog2(BUF_BYTES),
    localparam int PTR_W = $clog2(BUF_BYTES + 1)
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [NUM_CTX-1:0] closed_v,
    input  logic [PTR_W-1:0]   rd_len,
    input  logic [7:0]         rd_byte,
    output logic [CTX_W-1:0]   rd_ctx,
    output logic [IDX_W-1:0]   rd_idx,
    output logic               rel,
    output logic [CTX_W-1:0]   rel_ctx,
    output logic               pl_valid,
    input  logic               pl_ready,
    output logic [7:0]         pl_data,
    output logic               pl_last,
    output logic [CTX_W-1:0]   pl_ctx
);

    logic             busy;
    logic [CTX_W-1:0] cur, pick;
    logic [IDX_W-1:0] idx;

    always_comb begin
        pick = '0;
        for (int c = NUM_CTX - 1; c >= 0; c--) begin
            if (closed_v[c]) pick = CTX_W'(c);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            busy <= 1'b0;
            cur  <= '0;
            idx  <= '0;
        end else if (!busy) begin
            if (|closed_v) begin
                busy <= 1'b1;
                cur  <= pick;
                idx  <= '0;
            end
        end else if (pl_ready) begin
            if (pl_last) busy <= 1'b0;
            else         idx  <= idx + 1'b1;
        end
    end

    assign rd_ctx   = cur;
    assign rd_idx   = idx;
    assign pl_valid = busy;
    assign pl_data  = rd_byte;
    assign pl_ctx   = cur;
    assign pl_last  = busy && ((PTR_W'(idx) + 1'b1) == rd_len);
    assign rel      = busy && pl_ready && pl_last;
    assign rel_ctx  = cur;

    assert_stall_hold_R6: assert property (@(posedge clk) disable iff (rst)
        (pl_valid && !pl_ready) |=>
            (pl_valid && $stable(pl_data) && $stable(pl_ctx) && $stable(pl_last)));

    assert_ctx_steady_R7: assert property (@(posedge clk) disable iff (rst)
        (pl_valid && pl_ready && !pl_last) |=> (pl_valid && pl_ctx == $past(pl_ctx)));

    assert_sends_closed_R8: assert property (@(posedge clk) disable iff (rst)
        pl_valid |-> closed_v[pl_ctx]);

endmodule

// File: rtl/tsa_assembler.sv
module tsa_assembler
    import tsa_pkg::*;
#(
    parameter int NUM_SLOTS = 1024,
    parameter int NUM_CTX   = 128,
    parameter int BUF_BYTES = 16,
    parameter int LEN_W     = 4,
    localparam int SW = $clog2(NUM_SLOTS)
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               ts_valid,
    input  logic               ts_fs,
    input  logic [SW-1:0]      ts_slot,
    input  logic [7:0]         ts_byte,
    input  logic               cfg_we,
    input  logic [1:0]         cfg_sel,
    input  logic [SW-1:0]      cfg_addr,
    input  logic [7:0]         cfg_wdata,
    output logic               pl_valid,
    input  logic               pl_ready,
    output logic [7:0]         pl_data,
    output logic               pl_last,
    output logic [CTX_W-1:0]   pl_ctx,
    output logic [NUM_CTX-1:0] ovr_flags
);

    localparam int IDX_W = $clog2(BUF_BYTES);
    localparam int PTR_W = $clog2(BUF_BYTES + 1);

    cfg_op_e          op;
    map_ent_t         ent;
    logic             fs_evt, map_we, len_we, clr_we, rel;
    logic [CTX_W-1:0] rel_ctx, rd_ctx;
    logic [IDX_W-1:0] rd_idx;
    logic [PTR_W-1:0] rd_len;
    logic [7:0]       rd_byte;
    logic [NUM_CTX-1:0] closed_v;

    assign op     = cfg_op_e'(cfg_sel);
    assign map_we = cfg_we && (op == CFG_MAP);
    assign len_we = cfg_we && (op == CFG_LEN);
    assign clr_we = cfg_we && (op == CFG_CLR);
    assign fs_evt = ts_valid && ts_fs;

    tsa_slot_map #(.NUM_SLOTS(NUM_SLOTS)) u_map (
        .clk(clk), .rst(rst),
        .map_we(map_we), .map_addr(cfg_addr),
        .map_wdata(to_ent(cfg_wdata[CTX_W:0])),
        .fs_evt(fs_evt), .lk_slot(ts_slot), .lk_ent(ent)
    );

    tsa_ctx_store #(.NUM_CTX(NUM_CTX), .BUF_BYTES(BUF_BYTES), .LEN_W(LEN_W)) u_store (
        .clk(clk), .rst(rst), .fs_evt(fs_evt),
        .hit(ts_valid && ent.en), .hit_ctx(ent.ctx), .hit_byte(ts_byte),
        .len_we(len_we), .clr_we(clr_we), .cfg_ctx(cfg_addr[CTX_W-1:0]),
        .len_wdata(cfg_wdata[LEN_W-1:0]),
        .rel(rel), .rel_ctx(rel_ctx), .rd_ctx(rd_ctx), .rd_idx(rd_idx),
        .rd_byte(rd_byte), .rd_len(rd_len),
        .closed_v(closed_v), .ovr_v(ovr_flags)
    );

    tsa_drain #(.NUM_CTX(NUM_CTX), .BUF_BYTES(BUF_BYTES)) u_drain (
        .clk(clk), .rst(rst), .closed_v(closed_v),
        .rd_len(rd_len), .rd_byte(rd_byte), .rd_ctx(rd_ctx), .rd_idx(rd_idx),
        .rel(rel), .rel_ctx(rel_ctx),
        .pl_valid(pl_valid), .pl_ready(pl_ready), .pl_data(pl_data),
        .pl_last(pl_last), .pl_ctx(pl_ctx)
    );

    assert_quiet_after_reset_R1: assert property (@(posedge clk)
        $past(rst) |-> (!pl_valid && ovr_flags == '0));

endmodule

// File: tb/sim_tsa_assembler.sv
module sim_tsa_assembler;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         ts_valid = 1'b0, ts_fs = 1'b0;
    logic [9:0]   ts_slot = '0;
    logic [7:0]   ts_byte = '0;
    logic         cfg_we = 1'b0;
    logic [1:0]   cfg_sel = '0;
    logic [9:0]   cfg_addr = '0;
    logic [7:0]   cfg_wdata = '0;
    logic         pl_valid, pl_ready = 1'b0, pl_last;
    logic [7:0]   pl_data;
    logic [6:0]   pl_ctx;
    logic [127:0] ovr_flags;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;
    logic [7:0] exp_q [0:31];

    always #2.5 clk = ~clk;

    tsa_assembler u0 (
        .clk(clk), .rst(rst), .ts_valid(ts_valid), .ts_fs(ts_fs),
        .ts_slot(ts_slot), .ts_byte(ts_byte), .cfg_we(cfg_we),
        .cfg_sel(cfg_sel), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
        .pl_valid(pl_valid), .pl_ready(pl_ready), .pl_data(pl_data),
        .pl_last(pl_last), .pl_ctx(pl_ctx), .ovr_flags(ovr_flags)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic slot_in(input logic fs, input int slot, input logic [7:0] b);
        ts_valid = 1'b1; ts_fs = fs; ts_slot = 10'(slot); ts_byte = b;
        @(negedge clk);
        ts_valid = 1'b0; ts_fs = 1'b0;
    endtask

    task automatic host_wr(input logic [1:0] sel, input int addr, input logic [7:0] d);
        cfg_we = 1'b1; cfg_sel = sel; cfg_addr = 10'(addr); cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    // receives one payload of n bytes, stalls on byte 1 to test holding
    task automatic collect(input string req, input int ctx, input int n);
        for (int i = 0; i < n; i++) begin
            while (!pl_valid) @(negedge clk);
            chk({req, " R7 ctx"}, 32'(pl_ctx), 32'(ctx));
            chk({req, " R4 data"}, 32'(pl_data), 32'(exp_q[i]));
            chk({req, " R7 last"}, 32'(pl_last), 32'(i == n - 1));
            if (i == 1) begin
                @(negedge clk);
                chk({req, " R6 stall hold"},
                    {22'(0), pl_valid, pl_last, pl_data},
                    {22'(0), 1'b1, 1'(i == n - 1), exp_q[i]});
            end
            pl_ready = 1'b1;
            @(negedge clk);
            pl_ready = 1'b0;
        end
    endtask

    task automatic t_reset;
        chk("R1 valid", 32'(pl_valid), 0);
        chk("R1 ovr", 32'(ovr_flags != '0), 0);
        // unmapped slots: nothing may ever close
        slot_in(1'b1, 3, 8'hAA);
        slot_in(1'b0, 4, 8'hAB);
        slot_in(1'b1, 3, 8'hAC);
        repeat (3) @(negedge clk);
        chk("R2 unmapped discarded", 32'(pl_valid), 0);
        chk("R1 R2 no overrun", 32'(ovr_flags != '0), 0);
    endtask

    task automatic t_two_ctx;
        host_wr(2'd0, 3,  8'h85);
        host_wr(2'd0, 7,  8'h85);
        host_wr(2'd0, 10, 8'h82);
        host_wr(2'd1, 2, 8'd2);
        host_wr(2'd1, 5, 8'd2);
        slot_in(1'b1, 0, 8'hEE); slot_in(1'b0, 3, 8'h11);
        slot_in(1'b0, 7, 8'h12); slot_in(1'b0, 10, 8'h21);
        slot_in(1'b1, 0, 8'hEE); slot_in(1'b0, 3, 8'h13);
        slot_in(1'b0, 7, 8'h14); slot_in(1'b0, 10, 8'h22);
        chk("R5 not closed before length", 32'(pl_valid), 0);
        slot_in(1'b1, 0, 8'hEE);
        slot_in(1'b0, 3, 8'h15);
        chk("R9 closed ctx overrun", 32'(ovr_flags[5]), 1);
        chk("R10 other ctx flag", 32'(ovr_flags[2]), 0);
        exp_q[0] = 8'h21; exp_q[1] = 8'h22;
        collect("R8 lowest first ctx2", 2, 2);
        exp_q[0] = 8'h11; exp_q[1] = 8'h12; exp_q[2] = 8'h13; exp_q[3] = 8'h14;
        collect("R8 R10 ctx5", 5, 4);
        chk("R7 no trailing byte", 32'(pl_valid), 0);
        host_wr(2'd2, 5, 8'h00);
        chk("R9 clear", 32'(ovr_flags != '0), 0);
    endtask

    task automatic t_map_change;
        host_wr(2'd1, 2, 8'd1);
        slot_in(1'b1, 0, 8'hEE);
        host_wr(2'd0, 12, 8'h82);          // mid-frame: pending until next fs
        slot_in(1'b0, 10, 8'h30);
        slot_in(1'b0, 12, 8'h31);
        slot_in(1'b1, 0, 8'hEE);
        exp_q[0] = 8'h30;
        collect("R3 old map in frame", 2, 1);
        slot_in(1'b0, 10, 8'h34);
        slot_in(1'b0, 12, 8'h33);
        slot_in(1'b1, 0, 8'hEE);
        exp_q[0] = 8'h34; exp_q[1] = 8'h33;
        collect("R3 R4 new map", 2, 2);
        chk("R10 ctx5 idle", 32'(pl_valid), 0);
    endtask

    task automatic t_capacity;
        host_wr(2'd1, 9, 8'd0);            // length 0 acts as 1
        for (int s = 20; s < 38; s++) host_wr(2'd0, s, 8'h89);
        slot_in(1'b1, 0, 8'hEE);
        for (int s = 20; s < 38; s++) slot_in(1'b0, s, 8'(8'h40 + s - 20));
        chk("R9 full buffer overrun", 32'(ovr_flags[9]), 1);
        chk("R10 ctx2 flag clean", 32'(ovr_flags[2]), 0);
        slot_in(1'b1, 0, 8'hEE);
        for (int i = 0; i < 16; i++) exp_q[i] = 8'(8'h40 + i);
        collect("R5 len0 R9 capacity", 9, 16);
        chk("R7 length capped", 32'(pl_valid), 0);
        host_wr(2'd2, 9, 8'h00);
        chk("R9 clear ctx9", 32'(ovr_flags[9]), 0);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_two_ctx();
        t_map_change();
        t_capacity();
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual running expected done");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule